// File: doc/BRIEF.md
# MII Management Frame Command Engine

This block turns one 32-bit word written by software into a complete clause-22 style management transaction. It does not shift bits on a serial management line. It works on a modelled PHY register file of 32 registers, each 16 bits wide. A write to the frame register is decoded into a start code, an opcode, a PHY address, a register address and a data field. The addressed register is then written or read in the same clock cycle. Completion is reported by setting the turnaround low bit of the stored frame word.

The modelled PHY follows the usual control-register conventions. The reset bit and the autonegotiation-restart bit clear themselves. A restart reports autonegotiation complete. The `linkUp` input drives the link-status bit and the partner-ability bit. A separate configuration register sits beside the frame register. Its transceiver-presence bits cannot be changed by software.

Software reaches both registers through one bus. `busSel` = 0 selects the frame register and `busSel` = 1 selects the configuration register. `busRdData` shows the selected register without delay.

Top module: `mii_mgmt_engine`

## Requirements
- R1: After reset the frame register reads 0x00000000. The configuration register reads 0x00000100: bit 8 (internal transceiver present) is 1 and bit 9 (external transceiver present) is 0.
- R2: A frame write is stored on the next clock edge and then reads back with bit 16 forced to 1. All other header bits read back as written, including bit 17. The frame register does not change while no frame write occurs.
- R3: A frame write does not touch any PHY register if either check fails: the start code in bits 31:30 must be binary 01, and the PHY address in bits 27:23 must equal `PHY_ADDR` (default 1). When no access occurs, the word is stored unchanged apart from bit 16.
- R4: With a valid start and address, opcode 01 (bits 29:28) writes bits 15:0 into the register selected by bits 22:18. Opcode 10 stores the contents of that register in bits 15:0 of the frame word. Opcodes 00 and 11 perform no access.
- R5: Writing register 0 with bit 15 (reset) set stores bit 15 as 0 and bit 12 (autonegotiation enable) as 1.
- R6: Writing register 0 with bit 9 (restart) set stores bit 9 as 0 and sets register 1 bit 5 (autonegotiation complete). If `linkUp` is 1 in that cycle, it also sets register 1 bit 2 (link status) and register 5 bit 8 (partner 100BASE-TX full duplex).
- R7: Configuration register bits 9:8 ignore software writes. All other configuration bits store the written value.
- R8: Reset values of the PHY registers:
  - register 1 has bits 14, 5 and 3 set, plus bit 2 when `linkUp` is 1 during reset;
  - register 4 is 0x0100;
  - registers 2 and 3 hold `PHY_ID_HI` and `PHY_ID_LO`;
  - all other registers are 0.
- R9: Writes to registers 2 and 3 are ignored.
- R10: A falling edge on `linkUp` clears register 1 bit 2 and register 5 bit 8. A rising edge sets both. In the cycle of the edge, the link event overrides a software write to those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| busWrEn | input | 1 | Register write strobe |
| busSel | input | 1 | 0 selects the frame register, 1 selects the configuration register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Contents of the selected register |
| linkUp | input | 1 | Link state reported by the line side |

## Verification
A link edge and a software write to register 1 or register 5 can land on the same clock edge, so both update the same status bits at once. The bench drives `linkUp` and the frame write on the same falling clock edge, so both take effect at the next rising edge. It then reads the register back and expects the link event's value. A restart issued while the link is down is also checked: it must set only the autonegotiation-complete bit.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;
  localparam int FRAME_W    = 32;
  localparam int DATA_W     = 16;
  localparam int REG_ADDR_W = 5;
  localparam int REG_COUNT  = 1 << REG_ADDR_W;
  localparam int HDR_LSB    = 18;  // header slice passed to control: bits 31:18

  // PHY register indices and bit positions
  localparam int CTRL_IDX    = 0;
  localparam int STAT_IDX    = 1;
  localparam int ID_HI_IDX   = 2;
  localparam int ID_LO_IDX   = 3;
  localparam int ADV_IDX     = 4;
  localparam int PARTNER_IDX = 5;

  localparam int CTRL_RESET_BIT   = 15;
  localparam int CTRL_ANEN_BIT    = 12;
  localparam int CTRL_RESTART_BIT = 9;
  localparam int STAT_LINK_BIT    = 2;
  localparam int STAT_ANABLE_BIT  = 3;
  localparam int STAT_ANDONE_BIT  = 5;
  localparam int STAT_TXFD_BIT    = 14;
  localparam int PARTNER_TXFD_BIT = 8;

  localparam logic [1:0] START_CODE = 2'b01;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;

  localparam logic [FRAME_W-1:0] CFG_RO_MASK  = 32'h0000_0300;
  localparam logic [FRAME_W-1:0] CFG_RST_WORD = 32'h0000_0100;

  typedef struct packed {
    logic                  frameLoad;
    logic                  cfgLoad;
    logic                  phyWr;
    logic                  phyRd;
    logic                  linkRise;
    logic                  linkFall;
    logic [REG_ADDR_W-1:0] regAddr;
  } mgmtStrobes_t;
endpackage

// File: rtl/mii_mgmt_ctrl.sv
module mii_mgmt_ctrl
  import mii_mgmt_pkg::*;
#(
  parameter int PHY_ADDR = 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busWrEn,
  input  logic                       busSel,
  input  logic [FRAME_W-1:HDR_LSB]   frameHdr,
  input  logic                       linkUp,
  output mgmtStrobes_t               stb
);
  localparam logic [4:0] OWN_ADDR = PHY_ADDR[4:0];

  logic linkPrev;
  logic frameWr;
  logic headerOk;
  logic [1:0] opCode;

  always_ff @(posedge clk) begin
    if (!rstN) linkPrev <= linkUp;
    else       linkPrev <= linkUp;
  end

  always_comb begin
    frameWr  = busWrEn && !busSel;
    opCode   = frameHdr[29:28];
    headerOk = (frameHdr[31:30] == START_CODE) && (frameHdr[27:23] == OWN_ADDR);

    stb.frameLoad = frameWr;
    stb.cfgLoad   = busWrEn && busSel;
    stb.phyWr     = frameWr && headerOk && (opCode == OP_WRITE);
    stb.phyRd     = frameWr && headerOk && (opCode == OP_READ);
    stb.linkRise  = linkUp && !linkPrev;
    stb.linkFall  = !linkUp && linkPrev;
    stb.regAddr   = frameHdr[22:18];
  end
endmodule

// File: rtl/mii_mgmt_datapath.sv
module mii_mgmt_datapath
  import mii_mgmt_pkg::*;
#(
  parameter logic [DATA_W-1:0] PHY_ID_HI = 16'h0022,
  parameter logic [DATA_W-1:0] PHY_ID_LO = 16'h1619
) (
  input  logic               clk,
  input  logic               rstN,
  input  mgmtStrobes_t       stb,
  input  logic [FRAME_W-1:0] busWrData,
  input  logic               linkUp,
  output logic [FRAME_W-1:0] frameWord,
  output logic [FRAME_W-1:0] cfgWord
);
  logic [DATA_W-1:0] phyRegs  [REG_COUNT];
  logic [DATA_W-1:0] nextRegs [REG_COUNT];
  logic [DATA_W-1:0] cmdData;
  logic              restartHit;
  logic              idTarget;

  function automatic logic [DATA_W-1:0] resetValue(input int idx, input logic lnk);
    logic [DATA_W-1:0] v;
    v = '0;
    case (idx)
      STAT_IDX: begin
        v[STAT_TXFD_BIT]   = 1'b1;
        v[STAT_ANDONE_BIT] = 1'b1;
        v[STAT_ANABLE_BIT] = 1'b1;
        v[STAT_LINK_BIT]   = lnk;
      end
      ID_HI_IDX: v = PHY_ID_HI;
      ID_LO_IDX: v = PHY_ID_LO;
      ADV_IDX:   v[PARTNER_TXFD_BIT] = 1'b1;
      default:   v = '0;
    endcase
    return v;
  endfunction

  // Next state of the register file: command first, link events last
  always_comb begin
    for (int i = 0; i < REG_COUNT; i++) nextRegs[i] = phyRegs[i];
    cmdData    = busWrData[DATA_W-1:0];
    restartHit = 1'b0;
    idTarget   = (stb.regAddr == REG_ADDR_W'(ID_HI_IDX)) ||
                 (stb.regAddr == REG_ADDR_W'(ID_LO_IDX));
    if (stb.phyWr) begin
      if (stb.regAddr == REG_ADDR_W'(CTRL_IDX)) begin
        if (cmdData[CTRL_RESET_BIT]) begin
          cmdData[CTRL_RESET_BIT] = 1'b0;
          cmdData[CTRL_ANEN_BIT]  = 1'b1;
        end
        if (cmdData[CTRL_RESTART_BIT]) begin
          cmdData[CTRL_RESTART_BIT] = 1'b0;
          restartHit = 1'b1;
        end
      end
      if (!idTarget) nextRegs[stb.regAddr] = cmdData;
    end
    if (restartHit) begin
      nextRegs[STAT_IDX][STAT_ANDONE_BIT] = 1'b1;
      if (linkUp) begin
        nextRegs[STAT_IDX][STAT_LINK_BIT]       = 1'b1;
        nextRegs[PARTNER_IDX][PARTNER_TXFD_BIT] = 1'b1;
      end
    end
    if (stb.linkRise) begin
      nextRegs[STAT_IDX][STAT_LINK_BIT]       = 1'b1;
      nextRegs[PARTNER_IDX][PARTNER_TXFD_BIT] = 1'b1;
    end
    if (stb.linkFall) begin
      nextRegs[STAT_IDX][STAT_LINK_BIT]       = 1'b0;
      nextRegs[PARTNER_IDX][PARTNER_TXFD_BIT] = 1'b0;
    end
  end

  for (genvar gi = 0; gi < REG_COUNT; gi++) begin : g_phyReg
    always_ff @(posedge clk) begin
      if (!rstN) phyRegs[gi] <= resetValue(gi, linkUp);
      else       phyRegs[gi] <= nextRegs[gi];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameWord <= '0;
    end else if (stb.frameLoad) begin
      frameWord <= {busWrData[FRAME_W-1:17], 1'b1,
                    stb.phyRd ? phyRegs[stb.regAddr] : busWrData[DATA_W-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgWord <= CFG_RST_WORD;
    end else if (stb.cfgLoad) begin
      cfgWord <= (busWrData & ~CFG_RO_MASK) | (cfgWord & CFG_RO_MASK);
    end
  end
endmodule

// File: rtl/mii_mgmt_engine.sv
module mii_mgmt_engine
  import mii_mgmt_pkg::*;
#(
  parameter int                PHY_ADDR  = 1,
  parameter logic [DATA_W-1:0] PHY_ID_HI = 16'h0022,
  parameter logic [DATA_W-1:0] PHY_ID_LO = 16'h1619
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic               busSel,
  input  logic [FRAME_W-1:0] busWrData,
  output logic [FRAME_W-1:0] busRdData,
  input  logic               linkUp
);
  mgmtStrobes_t       stb;
  logic [FRAME_W-1:0] frameWord;
  logic [FRAME_W-1:0] cfgWord;

  mii_mgmt_ctrl #(.PHY_ADDR(PHY_ADDR)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busWrEn  (busWrEn),
    .busSel   (busSel),
    .frameHdr (busWrData[FRAME_W-1:HDR_LSB]),
    .linkUp   (linkUp),
    .stb      (stb)
  );

  mii_mgmt_datapath #(.PHY_ID_HI(PHY_ID_HI), .PHY_ID_LO(PHY_ID_LO)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busWrData (busWrData),
    .linkUp    (linkUp),
    .frameWord (frameWord),
    .cfgWord   (cfgWord)
  );

  assign busRdData = busSel ? cfgWord : frameWord;
endmodule

// File: rtl/mii_mgmt_checker.sv
module mii_mgmt_checker
  import mii_mgmt_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               busWrEn,
  input logic               busSel,
  input logic [FRAME_W-1:0] busWrData,
  input logic [FRAME_W-1:0] frameWord,
  input logic [FRAME_W-1:0] cfgWord,
  input mgmtStrobes_t       stb
);
  p_ta_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !busSel) |=> frameWord[16]);

  p_frame_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && !busSel) |=> $stable(frameWord));

  p_bad_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !busSel && busWrData[31:30] != START_CODE) |-> (!stb.phyWr && !stb.phyRd));

  p_cfg_ro_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busSel) |=> (cfgWord[9:8] == $past(cfgWord[9:8])));

  p_cfg_present_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (cfgWord[9:8] == 2'b01));
endmodule

bind mii_mgmt_engine mii_mgmt_checker i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busWrEn   (busWrEn),
  .busSel    (busSel),
  .busWrData (busWrData),
  .frameWord (frameWord),
  .cfgWord   (cfgWord),
  .stb       (stb)
);

// File: tb/test_mii_mgmt_engine.sv
`timescale 1ns/1ps
module test_mii_mgmt_engine;
  localparam int NV = 27;
  localparam logic [15:0] ID_HI = 16'h0022;
  localparam logic [15:0] ID_LO = 16'h1619;

  // frame word written, frame word expected on readback, requirement number
  localparam logic [31:0] VIN [NV] = '{
    32'h6084_0000, 32'h6088_0000, 32'h608C_0000, 32'h6090_0000, 32'h6094_0000,  // R8 reset values
    32'h509C_BEEF, 32'h609C_0000,                                              // R4 write/read reg7
    32'h209C_1234, 32'h511C_0000, 32'h609C_0000,                               // R3 bad start / addr
    32'h50FC_0F0F, 32'h60FC_0000, 32'h4084_5555, 32'h7084_0000, 32'h6084_0000, // R4 reg31, op00/op11
    32'h5080_8000, 32'h6080_0000,                                              // R5 reset bit
    32'h5084_0000, 32'h5080_0200, 32'h6080_0000, 32'h6084_0000, 32'h6094_0000, // R6 restart
    32'h5088_FFFF, 32'h6088_0000,                                              // R9 id read-only
    32'h609E_0000,                                                             // R2 bit17 kept
    32'h5080_8200, 32'h6080_0000                                               // R5 with restart
  };
  localparam logic [31:0] VEXP [NV] = '{
    32'h6085_402C, 32'h6089_0022, 32'h608D_1619, 32'h6091_0100, 32'h6095_0000,
    32'h509D_BEEF, 32'h609D_BEEF,
    32'h209D_1234, 32'h511D_0000, 32'h609D_BEEF,
    32'h50FD_0F0F, 32'h60FD_0F0F, 32'h4085_5555, 32'h7085_0000, 32'h6085_402C,
    32'h5081_8000, 32'h6081_1000,
    32'h5085_0000, 32'h5081_0200, 32'h6081_0000, 32'h6085_0024, 32'h6095_0100,
    32'h5089_FFFF, 32'h6089_0022,
    32'h609F_BEEF,
    32'h5081_8200, 32'h6081_1000
  };
  localparam int VREQ [NV] = '{
    8, 8, 8, 8, 8,
    4, 4,
    3, 3, 3,
    4, 4, 4, 4, 4,
    5, 5,
    6, 6, 6, 6, 6,
    9, 9,
    2,
    5, 5
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busSel = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        linkUp = 1'b1;
  int          nChecks = 0;
  int          nFails = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  mii_mgmt_engine #(.PHY_ADDR(1), .PHY_ID_HI(ID_HI), .PHY_ID_LO(ID_LO)) i_mii_mgmt_engine (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busSel(busSel),
    .busWrData(busWrData), .busRdData(busRdData), .linkUp(linkUp)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // drive one write on a falling edge; it takes effect at the next rising edge
  task automatic busWrite(input logic sel, input logic [31:0] word, input logic lnk);
    @(negedge clk);
    busWrEn = 1'b1; busSel = sel; busWrData = word; linkUp = lnk;
    @(negedge clk);
    busWrEn = 1'b0; busSel = sel;
  endtask

  task automatic frameCheck(input string tag, input logic [31:0] word, input logic [31:0] exp);
    busWrite(1'b0, word, linkUp);
    check(tag, busRdData, exp);
  endtask

  task automatic doReset(input logic lnk);
    @(negedge clk);
    rstN = 1'b0; linkUp = lnk;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    doReset(1'b1);
    busSel = 1'b0;
    check("R1 frame reset", busRdData, 32'h0000_0000);
    busSel = 1'b1; #0.1;
    check("R1 cfg reset", busRdData, 32'h0000_0100);
    busSel = 1'b0;

    for (int i = 0; i < NV; i++) begin
      frameCheck($sformatf("R%0d vector %0d", VREQ[i], i), VIN[i], VEXP[i]);
    end

    // R10: link falls with no software activity
    @(negedge clk); linkUp = 1'b0;
    @(negedge clk);
    frameCheck("R10 fall status", 32'h6084_0000, 32'h6085_0020);
    frameCheck("R10 fall partner", 32'h6094_0000, 32'h6095_0000);

    // R6: restart while the link is down sets only autonegotiation complete
    frameCheck("R6 clear status", 32'h5084_0000, 32'h5085_0000);
    frameCheck("R6 restart down", 32'h5080_0200, 32'h5081_0200);
    frameCheck("R6 status down", 32'h6084_0000, 32'h6085_0020);
    frameCheck("R6 partner down", 32'h6094_0000, 32'h6095_0000);

    // R10: rising edge in the same cycle as a write of 0 to register 5
    busWrite(1'b0, 32'h5094_0000, 1'b1);
    frameCheck("R10 rise vs write partner", 32'h6094_0000, 32'h6095_0100);
    frameCheck("R10 rise status", 32'h6084_0000, 32'h6085_0024);

    // R10: falling edge in the same cycle as a write setting the link bit
    busWrite(1'b0, 32'h5084_0004, 1'b0);
    frameCheck("R10 fall vs write status", 32'h6084_0000, 32'h6085_0000);

    // R7: configuration read-only bits
    busWrite(1'b1, 32'hFFFF_FFFF, linkUp);
    check("R7 cfg all ones", busRdData, 32'hFFFF_FDFF);
    busWrite(1'b1, 32'h0000_0000, linkUp);
    check("R7 cfg zero", busRdData, 32'h0000_0100);
    busSel = 1'b0; #0.1;
    check("R2 frame held", busRdData, 32'h6085_0000);

    // R8: reset with the link down leaves the link bit clear
    doReset(1'b0);
    busSel = 1'b0; #0.1;
    check("R1 frame after reset", busRdData, 32'h0000_0000);
    frameCheck("R8 status link down", 32'h6084_0000, 32'h6085_4028);
    frameCheck("R8 partner link down", 32'h6094_0000, 32'h6095_0000);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule